// File: doc/BRIEF.md
# Ping-Pong Stack Block Reversal Path

This block connects the end of a forward sample delay line to the start of a reverse delay line. Each sample that leaves the forward line reaches the reverse line in one of two ways. The first way keeps the arrival order and adds one register of delay. The second way reverses whole blocks of samples, so that a block leaves in the opposite order from the one it arrived in.

Block reversal uses two stacks that take turns. The filling stack pushes every incoming sample, and the draining stack pops one sample into the output register on each advance. A falling edge on the transfer control swaps the two roles. Block length therefore follows from how often the transfer control falls, not from a fixed length. An active-low shift enable gates all data movement. While it is high, nothing is pushed, popped or captured.

Top module: `drp_reversal_path`

## Requirements
- R1: During and right after reset, `rev_data` is 0, both stacks are empty and stack 0 has the filling role.
- R2: At a clock edge where `shift_n` is 1, `fwd_data` is not taken in, no stack changes and the selected output value stays the same; any pending role swap waits for the next edge where `shift_n` is 0.
- R3: When `rev_dis` is 1, after each edge with `shift_n` = 0, `rev_data` equals the `fwd_data` presented at that edge.
- R4: When `rev_dis` is 0, `rev_data` is the output register that receives one pop from the draining stack at every edge with `shift_n` = 0.
- R5: If `xfer` is sampled 1 at edge k-1 and 0 at edge k, the roles swap at edge k+1 when `shift_n` is 0 there, and otherwise at the first later edge with `shift_n` = 0.
- R6: A level of `xfer` that stays low, or stays high, causes no further swap.
- R7: The samples pushed between two swaps come out in reverse order, one per advance, after the second swap.
- R8: Each stack holds at most DEPTH samples. A push to a full stack is dropped and the samples already stored are kept.
- R9: A pop from an empty stack loads 0 into the output register.
- R10: At a swap edge the new filling stack starts empty and stores the sample of that edge as its first entry, and the new draining stack pops its top at that same edge.
- R11: Both paths track the input all the time, so a change of `rev_dis` switches `rev_data` at once between the two sources without disturbing either one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_data | input | DATA_W | Sample from the forward delay line |
| shift_n | input | 1 | Shift enable, active low; 1 freezes the block |
| xfer | input | 1 | Transfer control; a falling edge swaps the stack roles |
| rev_dis | input | 1 | 0 = block reversal, 1 = in-order pass-through |
| rev_data | output | DATA_W | Sample sent to the reverse delay line |

## Verification
The bench builds the block with DATA_W = 10 and DEPTH = 4. The small depth makes overflow drops and empty-stack pops appear within a few cycles. The bench sweeps the transfer period from 2 to 7 advances, so blocks both below and above the stack depth are covered, and it mixes in stall cycles and mode changes. A fixed sequence with known numbers also checks the swap latency, the reversed order, the drop of excess samples and a transfer level held low.

// File: rtl/drp_pkg.sv
package drp_pkg;
   // Role of a stack inside the ping-pong pair
   typedef enum logic {
      STK_FILL  = 1'b0,
      STK_DRAIN = 1'b1
   } stk_role_e;

   // Index of the stack that fills after an optional swap
   function automatic logic next_fill(input logic cur, input logic swap);
      return cur ^ swap;
   endfunction
endpackage

// File: rtl/drp_xfer_edge.sv
module drp_xfer_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer,
   input  logic adv,
   output logic swap
);
   logic xs_q, xp_q, pend_q, fall;

   // two sampling stages: the edge is seen one clock after xfer is captured low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xs_q <= 1'b0;
         xp_q <= 1'b0;
      end else begin
         xs_q <= xfer;
         xp_q <= xs_q;
      end
   end

   assign fall = xp_q & ~xs_q;
   assign swap = (fall | pend_q) & adv;

   // a fall seen while frozen waits for the next advance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (fall | pend_q) & ~adv;
   end

   a_r5_fall_swaps: assert property (@(posedge clk) disable iff (!rst_n)
      (xp_q && !xs_q && adv) |-> swap);
   a_r2_swap_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
      swap |-> adv);
   a_r6_no_swap_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (xs_q == xp_q && !pend_q) |-> !swap);
endmodule

// File: rtl/drp_lifo.sv
module drp_lifo #(
   parameter int DATA_W    = 10,
   parameter int DEPTH     = 16,
   parameter bit RESET_MEM = 1'b0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clr,
   input  logic                               push,
   input  logic                               pop,
   input  logic [DATA_W-1:0]                  din,
   output logic [DATA_W-1:0]                  top,
   output logic                               empty,
   output logic [$clog2(DEPTH+1)-1:0]         count
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      if (DATA_W < 1) $error("drp_lifo: DATA_W must be at least 1");
      if (DEPTH < 2)  $error("drp_lifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     top_idx;
   logic [AW-1:0]     wr_idx;
   logic              full, do_wr;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign top_idx = cnt_q - CW'(1);
   assign wr_idx  = clr ? '0 : cnt_q[AW-1:0];
   assign do_wr   = push & (clr | ~full);
   assign top     = empty ? '0 : mem[top_idx[AW-1:0]];
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr)               cnt_q <= push ? CW'(1) : '0;
      else if (push && !full)     cnt_q <= cnt_q + CW'(1);
      else if (pop && !empty)     cnt_q <= cnt_q - CW'(1);
   end

   generate
      if (RESET_MEM) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (do_wr) begin
               mem[wr_idx] <= din;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (do_wr) mem[wr_idx] <= din;
         end
      end
   endgenerate

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !clr) |=> (cnt_q == CW'(DEPTH)));
   a_r10_clr_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q <= CW'(1)));
endmodule

// File: rtl/drp_reversal_path.sv
module drp_reversal_path #(
   parameter int DATA_W    = 10,
   parameter int DEPTH     = 16,
   parameter bit RESET_MEM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic              shift_n,
   input  logic              xfer,
   input  logic              rev_dis,
   output logic [DATA_W-1:0] rev_data
);
   import drp_pkg::*;
   localparam int NSTK = 2;
   localparam int CW   = $clog2(DEPTH + 1);

   initial begin
      if (DATA_W < 1) $error("drp_reversal_path: DATA_W must be at least 1");
      if (DEPTH < 2)  $error("drp_reversal_path: DEPTH must be at least 2");
   end

   logic              adv, swap, sel_q, fill_idx;
   logic [DATA_W-1:0] pass_q, pop_q, rd_top;
   logic              rd_empty;
   logic [DATA_W-1:0] stk_top   [NSTK];
   logic              stk_empty [NSTK];
   logic [CW-1:0]     stk_cnt   [NSTK];

   assign adv = ~shift_n;

   drp_xfer_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .xfer (xfer),
      .adv  (adv),
      .swap (swap)
   );

   // stack 0 fills first after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= next_fill(sel_q, swap);
   end
   assign fill_idx = next_fill(sel_q, swap);

   generate
      for (genvar i = 0; i < NSTK; i++) begin : g_stk
         logic is_fill;
         assign is_fill = (fill_idx == 1'(i));
         drp_lifo #(
            .DATA_W   (DATA_W),
            .DEPTH    (DEPTH),
            .RESET_MEM(RESET_MEM)
         ) u_lifo (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (swap & is_fill),
            .push (adv & is_fill),
            .pop  (adv & ~is_fill),
            .din  (fwd_data),
            .top  (stk_top[i]),
            .empty(stk_empty[i]),
            .count(stk_cnt[i])
         );
      end
   endgenerate

   assign rd_top   = fill_idx ? stk_top[0]   : stk_top[1];
   assign rd_empty = fill_idx ? stk_empty[0] : stk_empty[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_q <= '0;
         pop_q  <= '0;
      end else if (adv) begin
         pass_q <= fwd_data;
         pop_q  <= rd_top;
      end
   end

   assign rev_data = rev_dis ? pass_q : pop_q;

   a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      shift_n |=> ($stable(rev_dis) -> $stable(rev_data)));
   a_r3_pass_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_n) |=> (rev_dis -> rev_data == $past(fwd_data)));
   a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && rd_empty) |=> (!rev_dis -> rev_data == '0));
   a_r10_one_filler: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (stk_cnt[sel_q] <= CW'(1)));
   a_r5_roles_still: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap) |=> $stable(sel_q));
endmodule

// File: tb/tb_drp_reversal_path.sv
module tb_drp_reversal_path;
   localparam int DW = 10;
   localparam int D  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] fwd_data = '0;
   logic          shift_n = 1'b1;
   logic          xfer = 1'b0;
   logic          rev_dis = 1'b0;
   logic [DW-1:0] rev_data;

   int total = 0;
   int bad   = 0;

   drp_reversal_path #(.DATA_W(DW), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .fwd_data(fwd_data), .shift_n(shift_n),
      .xfer(xfer), .rev_dis(rev_dis), .rev_data(rev_data)
   );

   always #10 clk = ~clk;

   // behavioural reference built from the requirements
   logic          m_xs, m_xp, m_pend, m_sel;
   int            m_cnt [2];
   logic [DW-1:0] m_mem [2][D];
   logic [DW-1:0] m_pass, m_pop;
   string         m_tag;

   task automatic m_reset();
      m_xs = 0; m_xp = 0; m_pend = 0; m_sel = 0;
      m_cnt[0] = 0; m_cnt[1] = 0; m_pass = '0; m_pop = '0;
   endtask

   task automatic m_edge(input logic [DW-1:0] d, input logic sn, input logic xf, input logic md);
      logic go, adv, sw;
      int w, r;
      go  = (m_xp & ~m_xs) | m_pend;
      adv = ~sn;
      sw  = go & adv;
      m_pend = go & ~adv;
      m_tag = md ? "R3" : "R7";
      if (sw) begin m_sel = ~m_sel; m_cnt[m_sel] = 0; if (!md) m_tag = "R10"; end
      if (adv) begin
         w = m_sel; r = !m_sel;
         if (m_cnt[w] < D) begin m_mem[w][m_cnt[w]] = d; m_cnt[w]++; end
         if (m_cnt[r] > 0) begin m_pop = m_mem[r][m_cnt[r]-1]; m_cnt[r]--; end
         else begin m_pop = '0; if (!md) m_tag = "R9"; end
         m_pass = d;
      end else m_tag = "R2";
      m_xp = m_xs; m_xs = xf;
   endtask

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: rev_data=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, clock, then compare at the next negedge
   task automatic step(input logic [DW-1:0] d, input logic sn, input logic xf, input logic md);
      fwd_data = d; shift_n = sn; xfer = xf; rev_dis = md;
      @(posedge clk);
      m_edge(d, sn, xf, md);
      @(negedge clk);
      check(m_tag, rev_data, md ? m_pass : m_pop);
   endtask

   task automatic do_reset();
      rst_n = 0; shift_n = 1; xfer = 0; fwd_data = '0;
      m_reset();
      repeat (2) @(negedge clk);
      check("R1", rev_data, '0);
      rst_n = 1;
   endtask

   task automatic direct(input logic [DW-1:0] d, input logic xf, input string req,
                         input logic [DW-1:0] exp);
      fwd_data = d; shift_n = 0; xfer = xf; rev_dis = 0;
      @(posedge clk);
      m_edge(d, 1'b0, xf, 1'b0);
      @(negedge clk);
      check(req, rev_data, exp);
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      rev_dis = 0;
      do_reset();
      rev_dis = 1;
      @(negedge clk);
      check("R1", rev_data, '0);
      rev_dis = 0;

      // fixed sequence: swap latency, reversal, overflow drop, steady low
      direct(10'd0, 1, "R9", 0);          // e1
      direct(10'd0, 0, "R9", 0);          // e2: fall sampled
      direct(10'd1, 0, "R10", 0);         // e3: swap, first entry of new block
      direct(10'd2, 0, "R4", 0);
      direct(10'd3, 0, "R4", 0);
      direct(10'd4, 0, "R4", 0);
      direct(10'd5, 0, "R8", 0);          // e7: dropped
      direct(10'd6, 1, "R8", 0);          // e8: dropped
      direct(10'd7, 0, "R8", 0);          // e9: dropped, fall sampled
      direct(10'd8, 0, "R7", 10'd4);      // e10: swap, pop top
      direct(10'd9, 0, "R7", 10'd3);
      direct(10'd10, 0, "R7", 10'd2);
      direct(10'd11, 0, "R7", 10'd1);
      direct(10'd12, 0, "R9", 10'd0);
      direct(10'd13, 0, "R6", 10'd0);     // xfer held low: no swap
      direct(10'd14, 0, "R6", 10'd0);

      // mode change exposes the pass path at once
      rev_dis = 1; #1;
      check("R11", rev_data, 10'd14);
      rev_dis = 0; #1;
      check("R11", rev_data, 10'd0);
      @(negedge clk);

      // sweep: transfer period 2..7, with and without stalls, both modes
      for (int md = 0; md < 2; md++) begin
         for (int stall = 0; stall < 2; stall++) begin
            for (int per = 2; per <= 7; per++) begin
               do_reset();
               for (int c = 0; c < per * 8; c++) begin
                  logic sn;
                  logic [DW-1:0] d;
                  sn = stall ? (((c * 7 + per) % 5) == 0) : 1'b0;
                  d  = DW'((per * 97 + c * 13 + 5) & 10'h3ff);
                  step(d, sn, (c % per) == 0, md[0]);
               end
            end
         end
      end

      // mode toggled while running
      do_reset();
      for (int c = 0; c < 60; c++) begin
         step(DW'(c * 29 + 3), (c % 9) == 4, (c % 5) == 0, ((c / 7) % 2) == 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule